// File: doc/BRIEF.md
# Dual-Capture Pulse Width Timer

This block measures how long an input signal stays in one state. A 16-bit counter runs freely at a rate chosen by a prescaler select. When the input makes the chosen active transition, the counter value is stored in capture register A and a one-cycle interrupt pulse is raised. When the input makes the opposite transition, the counter value is stored in capture register B. Software subtracts A from B to get the pulse width in count-clock ticks. Captures never clear the counter, so a series of pulses can be timed back to back.

The raw pin first passes through a synchronizer. It is then sampled once per count-clock tick. A level change is accepted only when two consecutive samples agree on the new level, so short glitches are rejected. A sticky flag records that the counter has wrapped. The flag stays set until it is cleared through a dedicated input.

Top module: `pulse_width_timer`

## Requirements
- R1: The counter advances by one on every count-clock tick and is never cleared by a capture. At divide-by-1, `cap_b - cap_a` equals the high time of a pulse in system clock cycles, and the next capture value is larger than the previous one.
- R2: With `edge_sel` = 01, a rising edge stores the counter in `cap_a` and raises `cap_irq`. A falling edge stores the counter in `cap_b` and raises no interrupt.
- R3: With `edge_sel` = 00, a falling edge stores the counter in `cap_a` and raises `cap_irq`. A rising edge stores the counter in `cap_b` and raises no interrupt.
- R4: With `edge_sel` = 11, every accepted edge stores the counter in `cap_a` and raises `cap_irq`, while `cap_b` keeps its value.
- R5: With `edge_sel` = 10, edges cause no capture and no interrupt.
- R6: The synchronized pin is sampled on each tick. A new level is accepted only after two consecutive samples show it. At divide-by-1, a one-cycle glitch is rejected and a two-cycle pulse is accepted.
- R7: `presc_sel` values 01 and 10 divide the system clock by 4 and by 16. A 40-cycle pulse at divide-by-4 and a 160-cycle pulse at divide-by-16 each measure 10.
- R8: With `presc_sel` = 00 the counter ticks every system cycle. With `presc_sel` = 11 there are no ticks, so the counter does not count, the pin is not sampled, and nothing is captured.
- R9: `cap_irq` is high for exactly one system clock cycle, in the same cycle in which `cap_a` shows its new value.
- R10: When the counter wraps from 0xFFFF to 0x0000, `ovf_flag` is set and stays set until `ovf_clr` is high at a clock edge. If a wrap and a clear happen at the same edge, the wrap wins.
- R11: While `rst_n` is low at a clock edge, the counter, both capture registers, the overflow flag and the filter history are cleared, and the accepted level becomes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Raw, asynchronous measured signal |
| presc_sel | input | 2 | Count-clock select: 00 /1, 01 /4, 10 /16, 11 stopped |
| edge_sel | input | 2 | Active edge: 00 falling, 01 rising, 11 both, 10 disabled |
| ovf_clr | input | 1 | Clears the overflow flag |
| cap_a | output | 16 | Counter value at the active edge |
| cap_b | output | 16 | Counter value at the opposite edge |
| cap_irq | output | 1 | One-cycle pulse when `cap_a` is loaded |
| ovf_flag | output | 1 | Sticky counter-wrap flag |

## Verification
The bench checks the width measured at every divide ratio. A design that delayed one edge more than the other, or that reset the counter on a capture, would report a width that is off by a few ticks. It sends a one-cycle glitch and then a two-cycle pulse to find the exact acceptance threshold. A filter needing only one sample would capture the glitch, and one needing three samples would miss the short pulse. The bench also runs the both-edge mode and the disabled mode, checking that `cap_b` stays unchanged in the first and that nothing moves in the second. It stops the prescaler to confirm that sampling stops too. Finally, it runs the counter through a full wrap to test that the overflow flag is sticky and that the clear works.

// File: rtl/pwt_pkg.sv
// Shared encodings for the pulse width timer.
// Assumes 2-bit select inputs on the top level.
package pwt_pkg;
    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_NONE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        DIV_ONE  = 2'b00,
        DIV_MID  = 2'b01,
        DIV_HIGH = 2'b10,
        DIV_STOP = 2'b11
    } presc_mode_e;
endpackage

// File: rtl/pwt_tick_gen.sv
// Count-clock enable generator.
// Produces a one-cycle tick at the rate picked by presc_sel:
// every cycle, every 2**MID_LOG2 cycles, every 2**HIGH_LOG2 cycles,
// or never. Assumes HIGH_LOG2 >= MID_LOG2 >= 1.
module pwt_tick_gen
    import pwt_pkg::*;
#(
    parameter int MID_LOG2  = 2,
    parameter int HIGH_LOG2 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] presc_sel,
    output logic       tick
);
    localparam int DIVW = HIGH_LOG2;

    logic [DIVW-1:0] div_q;

    // Free-running divider shared by both divided rates.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Decode the selected rate into a single-cycle enable.
    always_comb begin
        case (presc_mode_e'(presc_sel))
            DIV_ONE:  tick = 1'b1;
            DIV_MID:  tick = &div_q[MID_LOG2-1:0];
            DIV_HIGH: tick = &div_q;
            default:  tick = 1'b0;
        endcase
    end

    // R7
    high_rate_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && tick && presc_sel == DIV_HIGH && $past(presc_sel) == DIV_HIGH)
            |-> !$past(tick));
endmodule

// File: rtl/pwt_edge_filter.sv
// Input conditioning for the measured pin.
// Synchronizes the raw pin, samples it on each tick, and accepts a new
// level only after two consecutive samples agree. Emits one-cycle
// rise/fall pulses in the cycle after acceptance. Assumes pin_raw is
// asynchronous and SYNC_STAGES >= 1.
module pwt_edge_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin_raw,
    output logic rise_p,
    output logic fall_p
);
    logic pin_s;
    logic samp_q;
    logic lvl_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            logic s_q;
            // Single-stage synchronizer.
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= pin_raw;
            end
            assign pin_s = s_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] s_q;
            // Multi-stage synchronizer shift chain.
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= {s_q[SYNC_STAGES-2:0], pin_raw};
            end
            assign pin_s = s_q[SYNC_STAGES-1];
        end
    endgenerate

    // Tick-rate sampling with two-sample agreement before a level change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            lvl_q  <= 1'b0;
            rise_p <= 1'b0;
            fall_p <= 1'b0;
        end else begin
            rise_p <= 1'b0;
            fall_p <= 1'b0;
            if (tick) begin
                samp_q <= pin_s;
                if (pin_s == samp_q && pin_s != lvl_q) begin
                    lvl_q  <= pin_s;
                    rise_p <= pin_s;
                    fall_p <= ~pin_s;
                end
            end
        end
    end

    // R6
    level_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> $past(tick));

    // R6
    two_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> ($past(samp_q) == lvl_q));
endmodule

// File: rtl/pwt_capture_core.sv
// Free-running counter with two capture registers and a sticky wrap flag.
// Routes filtered edges to capture A (with interrupt) or capture B
// according to edge_sel. Assumes rise_p/fall_p are one-cycle pulses
// that never occur together.
module pwt_capture_core
    import pwt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rise_p,
    input  logic             fall_p,
    input  logic [1:0]       edge_sel,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cap_a,
    output logic [CNT_W-1:0] cap_b,
    output logic             irq,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt_q;
    logic             act_hit;
    logic             opp_hit;

    // Map filtered edges onto the active and opposite capture paths.
    always_comb begin
        case (edge_mode_e'(edge_sel))
            EDGE_RISE: begin act_hit = rise_p;          opp_hit = fall_p; end
            EDGE_FALL: begin act_hit = fall_p;          opp_hit = rise_p; end
            EDGE_BOTH: begin act_hit = rise_p | fall_p; opp_hit = 1'b0;   end
            default:   begin act_hit = 1'b0;            opp_hit = 1'b0;   end
        endcase
    end

    // Free-running counter, advanced by the count-clock tick only.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky wrap flag; a wrap takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf <= 1'b0;
        else if (tick && &cnt_q)   ovf <= 1'b1;
        else if (ovf_clr)          ovf <= 1'b0;
    end

    // Capture registers and the interrupt pulse aligned with capture A.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a <= '0;
            cap_b <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= act_hit;
            if (act_hit) cap_a <= cnt_q;
            if (opp_hit) cap_b <= cnt_q;
        end
    end

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick)) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick)) |-> $stable(cnt_q));

    // R10
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick) && &$past(cnt_q)) |-> ovf);

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4
    both_holds_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && edge_sel == EDGE_BOTH && $past(edge_sel) == EDGE_BOTH)
            |-> $stable(cap_b));
endmodule

// File: rtl/pulse_width_timer.sv
// Top level of the dual-capture pulse width timer.
// Joins the tick generator, input filter and capture core.
// Assumes a single clock domain except for the raw pin.
module pulse_width_timer #(
    parameter int CNT_W       = 16,
    parameter int MID_LOG2    = 2,
    parameter int HIGH_LOG2   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [1:0]       presc_sel,
    input  logic [1:0]       edge_sel,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cap_a,
    output logic [CNT_W-1:0] cap_b,
    output logic             cap_irq,
    output logic             ovf_flag
);
    logic tick;
    logic rise_p;
    logic fall_p;

    pwt_tick_gen #(
        .MID_LOG2 (MID_LOG2),
        .HIGH_LOG2(HIGH_LOG2)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .presc_sel(presc_sel),
        .tick     (tick)
    );

    pwt_edge_filter #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .pin_raw(pin_in),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    pwt_capture_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .edge_sel(edge_sel),
        .ovf_clr (ovf_clr),
        .cap_a   (cap_a),
        .cap_b   (cap_b),
        .irq     (cap_irq),
        .ovf     (ovf_flag)
    );
endmodule

// File: tb/pulse_width_timer_test.sv
// Scoreboard bench: driver tasks push expected interrupts into a queue,
// a monitor pops one per observed interrupt pulse.
module pulse_width_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [1:0]  presc_sel = 2'b00;
    logic [1:0]  edge_sel = 2'b01;
    logic        ovf_clr = 1'b0;
    logic [15:0] cap_a;
    logic [15:0] cap_b;
    logic        cap_irq;
    logic        ovf_flag;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;
    string exp_q[$];

    always #2 clk = ~clk;

    pulse_width_timer uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .presc_sel(presc_sel),
        .edge_sel(edge_sel), .ovf_clr(ovf_clr), .cap_a(cap_a), .cap_b(cap_b),
        .cap_irq(cap_irq), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_irq(input string tag);
        exp_q.push_back(tag);
    endtask

    task automatic sb_drain(input string tag);
        chk(tag, "pending expected interrupts", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic pulse(input logic lvl, input int w, input int settle);
        pin_in = lvl;
        cyc(w);
        pin_in = ~lvl;
        cyc(settle);
    endtask

    // Monitor: pops one expected item per interrupt and checks pulse shape (R9).
    logic        prev_irq = 1'b0;
    logic [15:0] prev_a   = '0;
    always @(negedge clk) begin
        if (rst_n && cap_irq) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errs++;
                $display("FAIL R9 unexpected interrupt: actual 1 expected 0");
            end else begin
                void'(exp_q.pop_front());
            end
            if (prev_irq) begin
                n_checks++; n_errs++;
                $display("FAIL R9 interrupt longer than one cycle: actual 2 expected 1");
            end
            if (cap_a == prev_a) begin
                n_checks++; n_errs++;
                $display("FAIL R9 cap_a not updated with interrupt: actual %0d expected changed", cap_a);
            end
        end
        prev_irq = cap_irq;
        prev_a   = cap_a;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        logic [15:0] a0, b0, a1, a2, prev_b;

        // R11: reset state
        cyc(4);
        chk("R11", "cap_a after reset", cap_a, 0);
        chk("R11", "cap_b after reset", cap_b, 0);
        chk("R11", "irq after reset", cap_irq, 0);
        chk("R11", "ovf after reset", ovf_flag, 0);
        rst_n = 1'b1;
        cyc(10);

        // R2: rising active, R1 exact width at divide-by-1
        expect_irq("R2");
        pulse(1'b1, 25, 20);
        chk("R1", "width 25 at /1", 16'(cap_b - cap_a), 25);
        chk("R2", "cap_b after cap_a", (cap_b > cap_a), 1);
        sb_drain("R2");
        prev_b = cap_b;

        expect_irq("R1");
        pulse(1'b1, 7, 20);
        chk("R1", "counter not cleared by capture", (cap_a > prev_b), 1);
        chk("R1", "width 7 at /1", 16'(cap_b - cap_a), 7);
        sb_drain("R1");

        // R6: one-cycle glitch rejected, two-cycle pulse accepted
        a0 = cap_a; b0 = cap_b;
        pulse(1'b1, 1, 20);
        chk("R6", "glitch leaves cap_a", cap_a, a0);
        chk("R6", "glitch leaves cap_b", cap_b, b0);
        sb_drain("R6");
        expect_irq("R6");
        pulse(1'b1, 2, 20);
        chk("R6", "two-cycle pulse width", 16'(cap_b - cap_a), 2);
        sb_drain("R6");

        // R3: falling active; idle-high rising edge goes to cap_b only
        edge_sel = 2'b00;
        a0 = cap_a; b0 = cap_b;
        pin_in = 1'b1;
        cyc(20);
        chk("R3", "rising edge leaves cap_a", cap_a, a0);
        chk("R3", "rising edge loads cap_b", (cap_b != b0), 1);
        sb_drain("R3");
        expect_irq("R3");
        pulse(1'b0, 30, 20);
        chk("R3", "low width 30", 16'(cap_b - cap_a), 30);
        sb_drain("R3");

        // R5: disabled edge code
        edge_sel = 2'b10;
        pin_in = 1'b0;
        cyc(20);
        a0 = cap_a; b0 = cap_b;
        pulse(1'b1, 12, 20);
        chk("R5", "cap_a unchanged", cap_a, a0);
        chk("R5", "cap_b unchanged", cap_b, b0);
        sb_drain("R5");

        // R4: both edges into cap_a
        edge_sel = 2'b11;
        b0 = cap_b;
        expect_irq("R4");
        expect_irq("R4");
        pin_in = 1'b1;
        cyc(15);
        a1 = cap_a;
        cyc(3);
        pin_in = 1'b0;
        cyc(20);
        a2 = cap_a;
        chk("R4", "both-edge width 18", 16'(a2 - a1), 18);
        chk("R4", "cap_b held", cap_b, b0);
        sb_drain("R4");

        // R7: divided rates
        edge_sel = 2'b01;
        presc_sel = 2'b01;
        cyc(8);
        expect_irq("R7");
        pulse(1'b1, 40, 40);
        chk("R7", "40 cycles at /4", 16'(cap_b - cap_a), 10);
        sb_drain("R7");
        presc_sel = 2'b10;
        cyc(32);
        expect_irq("R7");
        pulse(1'b1, 160, 100);
        chk("R7", "160 cycles at /16", 16'(cap_b - cap_a), 10);
        sb_drain("R7");

        // R8: stopped prescaler
        presc_sel = 2'b11;
        cyc(4);
        a0 = cap_a; b0 = cap_b;
        pulse(1'b1, 50, 50);
        chk("R8", "no capture A when stopped", cap_a, a0);
        chk("R8", "no capture B when stopped", cap_b, b0);
        sb_drain("R8");

        // R10: wrap and sticky flag, after a fresh reset
        presc_sel = 2'b00;
        rst_n = 1'b0;
        cyc(3);
        chk("R11", "ovf cleared by reset", ovf_flag, 0);
        chk("R11", "cap_a cleared by reset", cap_a, 0);
        rst_n = 1'b1;
        cyc(60000);
        chk("R10", "no wrap yet", ovf_flag, 0);
        cyc(5600);
        chk("R10", "wrap sets flag", ovf_flag, 1);
        cyc(100);
        chk("R10", "flag sticky", ovf_flag, 1);
        ovf_clr = 1'b1;
        cyc(1);
        ovf_clr = 1'b0;
        chk("R10", "clear input", ovf_flag, 0);
        cyc(5);
        chk("R10", "stays clear", ovf_flag, 0);
        sb_drain("R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule